// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

This block is a small general-purpose I/O port of `NPIN` pins (eight by default) with a synchronous register port. Software drives the pins through an output-value register and an output-enable register. It reads the pins back through a synchronized input view. Two parameters fix which pins software may touch. `CHG_BITS` limits the set-bits and clear-bits writes on output values. `CHG_DIR` limits the make-input and make-output writes on direction.

Each pin has a three-bit trigger mode that turns its synchronized level, its edges, or a one-shot software trigger into a pending interrupt bit. Pending bits are masked and ORed into one interrupt line. A write of ones to the acknowledge address clears them. Reads are combinational from `rd_addr`. Writes take effect at the clock edge where `wr_en` is high.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every readable register reads 0: output values (0x0), output enable (0x4), modes (0x7), mask (0x8) and pending (0x9). `irq` is 0 and every pin mode is off (code 0).
- R2: A write to address 0x0 loads all output-value bits directly. They drive `pin_out` and read back at 0x0 from the next cycle.
- R3: A write to 0x1 ORs `wr_data & CHG_BITS` into the output values. A write to 0x2 clears the bits in `wr_data & CHG_BITS`. Pins outside `CHG_BITS` keep their value.
- R4: Address 0x4 reads and writes output enable directly (1 = output). A write to 0x5 clears enable bits in `wr_data & CHG_DIR`, and a read of 0x5 returns the inverted enable (1 = input). A write to 0x6 sets enable bits in `wr_data & CHG_DIR`, and a read of 0x6 returns the enable.
- R5: Address 0x3 returns the pins through a two-flop synchronizer. A pin change appears in the read two clock edges after it is applied, not one.
- R6: Modes sit at address 0x7, three bits per pin, pin i at bits [3i+2:3i]. Code 1 is high level and code 2 is low level. A level-mode pin is pending again in every cycle its level holds, even right after an acknowledge.
- R7: Code 3 is software set. Writing the mode field of a pin from another code to 3 makes that pin pending once, and the bit stays pending until acknowledged.
- R8: Code 4 is rising edge, code 5 falling edge and code 6 any edge. An edge on the synchronized pin sets a pending bit that stays until acknowledged. A pin in mode 0 (off) never becomes pending.
- R9: Address 0x9 reads raw pending bits, and address 0xA reads pending ANDed with the mask at 0x8. `irq` is 1 exactly when any masked bit is 1.
- R10: A write to 0xB clears each pending bit whose data bit is 1. Zero bits leave pending state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Combinational read data |
| pin_in | input | NPIN | Asynchronous pin levels |
| pin_out | output | NPIN | Output values to the pads |
| pin_oe | output | NPIN | Per-pin output enable, 1 = drive |
| irq | output | 1 | OR of masked pending bits |

## Verification
Six pins are configured at once with different modes: high, low, set, rise, fall and any. The pins are then swept all-low, all-high and all-low again, so one pending word shows which modes answer to which transition. An acknowledge of all ones after each step separates level modes, which come back at once, from sticky edge and set modes, which clear. A pin left off but toggled with the rest shows that mode 0 is silent. Masked reads with a single-bit mask, and an all-zero acknowledge, separate the raw view from the masked view and the line. The set, clear and direction writes use all-ones arguments, so that any leak through the changeable masks shows up on the fixed pins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        TRG_OFF  = 3'd0,
        TRG_HIGH = 3'd1,
        TRG_LOW  = 3'd2,
        TRG_SET  = 3'd3,
        TRG_RISE = 3'd4,
        TRG_FALL = 3'd5,
        TRG_ANY  = 3'd6
    } trig_mode_e;

    localparam int A_DOUT   = 0;
    localparam int A_SET    = 1;
    localparam int A_CLR    = 2;
    localparam int A_DIN    = 3;
    localparam int A_OE     = 4;
    localparam int A_MKIN   = 5;
    localparam int A_MKOUT  = 6;
    localparam int A_MODE   = 7;
    localparam int A_MASK   = 8;
    localparam int A_RAW    = 9;
    localparam int A_MASKED = 10;
    localparam int A_ACK    = 11;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= async_in;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;
endmodule

// File: rtl/gpio_trig_cell.sv
module gpio_trig_cell
    import gpio_irq_pkg::*;
(
    input  trig_mode_e mode,
    input  logic       cur,
    input  logic       prev,
    input  logic       enter_set,
    output logic       evt
);
    logic cond;

    always_comb begin
        unique case (mode)
            TRG_HIGH: cond = cur;
            TRG_LOW:  cond = ~cur;
            TRG_RISE: cond = cur & ~prev;
            TRG_FALL: cond = ~cur & prev;
            TRG_ANY:  cond = cur ^ prev;
            default:  cond = 1'b0;
        endcase
        evt = cond | enter_set;
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int              NPIN     = 8,
    parameter int              AW       = 4,
    parameter int              DW       = 32,
    parameter logic [NPIN-1:0] CHG_BITS = 8'h7F,
    parameter logic [NPIN-1:0] CHG_DIR  = 8'hFC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic            irq
);
    localparam int MW = 3 * NPIN;

    typedef struct packed {
        logic [NPIN-1:0]             dout;
        logic [NPIN-1:0]             oe;
        trig_mode_e [NPIN-1:0]       mode;
        logic [NPIN-1:0]             mask;
        logic [NPIN-1:0]             pend;
    } port_state_t;

    port_state_t st_q, st_d;

    logic [NPIN-1:0] sync_cur, sync_prev;
    logic [NPIN-1:0] enter_set;
    logic [NPIN-1:0] evt;
    logic [NPIN-1:0] wmask;
    logic [MW-1:0]   mode_flat;
    logic [NPIN-1:0] pend_vec;
    logic            mode_wr;
    logic            unused_wr_hi;

    assign wmask        = wr_data[NPIN-1:0];
    assign unused_wr_hi = ^wr_data[DW-1:MW];
    assign mode_wr      = wr_en && (wr_addr == AW'(A_MODE));

    gpio_in_sync #(.W(NPIN)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .cur      (sync_cur),
        .prev     (sync_prev)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        trig_mode_e new_mode;
        assign new_mode     = trig_mode_e'(wr_data[3*i +: 3]);
        assign enter_set[i] = mode_wr && (new_mode == TRG_SET) && (st_q.mode[i] != TRG_SET);
        assign mode_flat[3*i +: 3] = st_q.mode[i];

        gpio_trig_cell cell_i (
            .mode      (st_q.mode[i]),
            .cur       (sync_cur[i]),
            .prev      (sync_prev[i]),
            .enter_set (enter_set[i]),
            .evt       (evt[i])
        );
    end

    always_comb begin
        logic [NPIN-1:0] ack;
        st_d = st_q;
        ack  = '0;
        if (wr_en) begin
            case (int'(wr_addr))
                A_DOUT:  st_d.dout = wmask;
                A_SET:   st_d.dout = st_q.dout | (wmask & CHG_BITS);
                A_CLR:   st_d.dout = st_q.dout & ~(wmask & CHG_BITS);
                A_OE:    st_d.oe   = wmask;
                A_MKIN:  st_d.oe   = st_q.oe & ~(wmask & CHG_DIR);
                A_MKOUT: st_d.oe   = st_q.oe | (wmask & CHG_DIR);
                A_MODE: begin
                    for (int i = 0; i < NPIN; i++)
                        st_d.mode[i] = trig_mode_e'(wr_data[3*i +: 3]);
                end
                A_MASK:  st_d.mask = wmask;
                A_ACK:   ack       = wmask;
                default: ;
            endcase
        end
        st_d.pend = (st_q.pend & ~ack) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dout <= '0;
            st_q.oe   <= '0;
            st_q.mask <= '0;
            st_q.pend <= '0;
            for (int i = 0; i < NPIN; i++)
                st_q.mode[i] <= TRG_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (int'(rd_addr))
            A_DOUT:   rd_data[NPIN-1:0] = st_q.dout;
            A_DIN:    rd_data[NPIN-1:0] = sync_cur;
            A_OE:     rd_data[NPIN-1:0] = st_q.oe;
            A_MKIN:   rd_data[NPIN-1:0] = ~st_q.oe;
            A_MKOUT:  rd_data[NPIN-1:0] = st_q.oe;
            A_MODE:   rd_data[MW-1:0]   = mode_flat;
            A_MASK:   rd_data[NPIN-1:0] = st_q.mask;
            A_RAW:    rd_data[NPIN-1:0] = st_q.pend;
            A_MASKED: rd_data[NPIN-1:0] = st_q.pend & st_q.mask;
            default:  rd_data = '0;
        endcase
    end

    assign pend_vec = st_q.pend;
    assign pin_out  = st_q.dout;
    assign pin_oe   = st_q.oe;
    assign irq      = |(st_q.pend & st_q.mask);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int              NPIN     = 8,
    parameter int              AW       = 4,
    parameter int              DW       = 32,
    parameter logic [NPIN-1:0] CHG_BITS = 8'h7F,
    parameter logic [NPIN-1:0] CHG_DIR  = 8'hFC
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     wr_addr,
    input logic [NPIN-1:0]   wr_lo,
    input logic [AW-1:0]     rd_addr,
    input logic [DW-1:0]     rd_data,
    input logic              irq,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_oe,
    input logic [NPIN-1:0]   pend,
    input logic [3*NPIN-1:0] mode_flat
);
    // R3: set/clear never move pins outside the changeable-bits mask
    assert_set_filter_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == AW'(A_SET) || wr_addr == AW'(A_CLR)))
        |=> $stable(pin_out & ~CHG_BITS));

    // R4: direction writes never move enables outside the changeable-direction mask
    assert_dir_filter_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == AW'(A_MKIN) || wr_addr == AW'(A_MKOUT)))
        |=> $stable(pin_oe & ~CHG_DIR));

    // R9: the line agrees with the masked view on the read port
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == AW'(A_MASKED)) |-> (irq == (rd_data != '0)));

    for (genvar i = 0; i < NPIN; i++) begin : g_chk
        // R8: a pin in off mode stays quiet
        assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend[i] && mode_flat[3*i +: 3] == 3'd0 && !(wr_en && wr_addr == AW'(A_MODE)))
            |=> !pend[i]);

        // R10: acknowledge of an off pin clears it
        assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == AW'(A_ACK) && wr_lo[i] && mode_flat[3*i +: 3] == 3'd0)
            |=> !pend[i]);

        // R10: a pending bit only falls after an acknowledge with a 1 in its position
        assert_fall_needs_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend[i]) |-> $past(wr_en && wr_addr == AW'(A_ACK) && wr_lo[i]));
    end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
    .NPIN(NPIN), .AW(AW), .DW(DW), .CHG_BITS(CHG_BITS), .CHG_DIR(CHG_DIR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_lo     (wr_data[NPIN-1:0]),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .irq       (irq),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pend      (pend_vec),
    .mode_flat (mode_flat)
);

// File: tb/gpio_irq_port_tb_top.sv
module gpio_irq_port_tb_top;
    localparam int         NPIN = 8;
    localparam int         AW   = 4;
    localparam int         DW   = 32;
    localparam logic [7:0] CB   = 8'h7F;
    localparam logic [7:0] CD   = 8'hFC;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [DW-1:0]   rd_data;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] pin_out, pin_oe;
    logic            irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_line;
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #5 clk = ~clk;

    gpio_irq_port #(.NPIN(NPIN), .AW(AW), .DW(DW), .CHG_BITS(CB), .CHG_DIR(CD)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    // monitor: pops one expectation per falling edge and compares
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_item_t it;
            logic [31:0] act;
            it  = sb_q.pop_front();
            act = it.is_line ? {31'b0, irq} : rd_data;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_rd(input int a, input logic [31:0] e, input string tag);
        exp_item_t it;
        @(posedge clk); #1;
        rd_addr = AW'(a);
        it.is_line = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_line(input logic e, input string tag);
        exp_item_t it;
        @(posedge clk); #1;
        it.is_line = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_pins(input logic [7:0] e, input bit oe_sel, input string tag);
        @(negedge clk);
        n_cmp++;
        if ((oe_sel ? pin_oe : pin_out) !== e) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, oe_sel ? pin_oe : pin_out, e);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic drive_pins(input logic [7:0] v);
        @(posedge clk); #1;
        pin_in = v;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_rd(0, 32'h0, "R1 dout after reset");
        expect_rd(4, 32'h0, "R1 oe after reset");
        expect_rd(7, 32'h0, "R1 modes after reset");
        expect_rd(8, 32'h0, "R1 mask after reset");
        expect_rd(9, 32'h0, "R1 pending after reset");
        expect_line(1'b0, "R1 irq after reset");

        // R2 direct output write
        wr(0, 32'h55);
        expect_rd(0, 32'h55, "R2 dout readback");
        expect_pins(8'h55, 1'b0, "R2 pin_out");

        // R3 filtered set and clear
        wr(1, 32'hFF);
        expect_rd(0, 32'h7F, "R3 set filtered");
        wr(0, 32'hFF);
        wr(2, 32'hFF);
        expect_rd(0, 32'h80, "R3 clear filtered");
        wr(2, 32'h00);
        expect_pins(8'h80, 1'b0, "R3 clear zero arg");

        // R4 direction
        wr(4, 32'h00);
        wr(6, 32'hFF);
        expect_rd(4, 32'hFC, "R4 make-output filtered");
        expect_rd(5, 32'h03, "R4 input view");
        wr(5, 32'h0C);
        expect_rd(6, 32'hF0, "R4 make-input");
        wr(4, 32'hFF);
        wr(5, 32'hFF);
        expect_pins(8'h03, 1'b1, "R4 fixed pins keep output");

        // R5 synchronizer latency
        drive_pins(8'hA5);
        expect_rd(3, 32'h00, "R5 one edge not yet visible");
        expect_rd(3, 32'hA5, "R5 visible after two edges");

        // interrupt setup
        drive_pins(8'h00);
        idle(4);
        wr(8, 32'hFF);
        wr(7, 32'h358D1);
        expect_rd(7, 32'h358D1, "R6 mode readback");
        expect_rd(9, 32'h06, "R7 set entry and low level pending");
        wr(11, 32'hFF);
        expect_rd(9, 32'h02, "R6 low level re-asserts, R7 set cleared");
        wr(7, 32'h358D1);
        expect_rd(9, 32'h02, "R7 rewrite of same set mode does not retrigger");

        drive_pins(8'h7F);
        idle(4);
        expect_rd(9, 32'h2B, "R8 rise/any/high pending, off quiet");
        wr(11, 32'hFF);
        expect_rd(9, 32'h01, "R6 high level re-asserts after ack");

        drive_pins(8'h00);
        idle(4);
        expect_rd(9, 32'h33, "R8 fall/any/low pending, off quiet");

        // R9 masking
        wr(8, 32'h10);
        expect_rd(10, 32'h10, "R9 masked view");
        expect_line(1'b1, "R9 irq on masked bit");

        // R10 acknowledge
        wr(11, 32'h10);
        expect_rd(9, 32'h23, "R10 ack clears only bit4");
        expect_line(1'b0, "R9 irq low with masked bit clear");
        wr(11, 32'h00);
        expect_rd(9, 32'h23, "R10 zero ack no effect");

        idle(2);
        finish_run();
    end
endmodule